// File: doc/BRIEF.md
# ECC Mode Control Register with Command-Coded Writes

This block holds the operating mode of a memory ECC subsystem. Software changes it by writing one full cache line. The line arrives as sixteen 64-bit beats on a valid/ready stream. Every beat must carry the same word. A 3-bit command in bits 18:16 of that word picks one action:
- switch between fast and slow memory timing;
- turn ECC error checking on or off;
- send a one-cycle NMI-clear pulse;
- permit an update of the 7-bit ECC-chip configuration held in bits 6:0.

The new state takes effect only once the whole line has arrived. A line whose beats disagree is thrown away, and a sticky flag records that this happened. A select input marks the beats that belong to this register. This select stands in for the bank-address decode of the memory controller.

The stream follows the usual rules. A beat is transferred in any cycle where `in_valid` and `in_ready` are both high. The block lowers `in_ready` for exactly one cycle, the cycle right after the sixteenth selected beat is accepted. It uses that cycle to apply the line. A source holding `in_valid` high during that cycle must keep its data and wait. Beats transferred with `in_sel` low are taken and dropped.

Top module: `ecc_mode_ctl`

## Requirements
- R1: After reset, `fast_mode` is 0 (slow timing), `chk_en` is 0, `ecc_cfg` is 7'h03 (chip mode 3, normal correction, with bits 6:3 all zero), `cfg_mismatch` is 0 and `nmi_clr` is 0.
- R2: A committed line with command 0 sets `fast_mode` to 1. A committed line with command 1 sets it to 0.
- R3: A committed line with command 5 sets `chk_en` to 1. A committed line with command 6 sets it to 0.
- R4: A committed line with command 2 loads bits 6:0 of the word into `ecc_cfg`. The meaning of those bits is:
  - bits 2:0 are the chip mode (0 error-data out, 1 diagnostic out, 2 generate-detect, 3 correct, 4 checkbit inject);
  - bit 3 clears the chip's internal registers;
  - bit 4 selects a single FIFO;
  - bit 5 selects odd parity;
  - bit 6 routes the mode register to the output mux.
  With any other command, `ecc_cfg` keeps its value. Bits 15:7 are ignored.
- R5: A committed line with command 3 drives `nmi_clr` high for exactly one cycle and changes no other state.
- R6: A committed line with command 4 or 7 changes no output.
- R7: The state changes only after all sixteen selected beats of a line have been accepted. Outputs take their new values at the clock edge that ends the cycle in which `in_ready` is low. A partial line changes nothing.
- R8: A line in which any beat differs from the first, in any of the 64 bits, is discarded. `cfg_mismatch` then goes high and stays high until reset.
- R9: `rd_data` always returns `ecc_cfg` in bits 6:0, `fast_mode` in bit 16 and `chk_en` in bit 17. All other bits read as 0.
- R10: `in_ready` is low for exactly the one cycle after the sixteenth selected beat is accepted, and high otherwise. Beats accepted with `in_sel` low are not counted and not compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat accepted when high with in_valid |
| in_sel | input | 1 | Beat addressed to this register |
| in_data | input | 64 | Beat data |
| fast_mode | output | 1 | Fast memory timing selected |
| chk_en | output | 1 | ECC error checking enabled |
| nmi_clr | output | 1 | One-cycle NMI clear pulse |
| ecc_cfg | output | 7 | ECC-chip configuration bits |
| cfg_mismatch | output | 1 | Sticky: an inconsistent line was discarded |
| rd_data | output | 64 | Readback word |

## Verification
The hardest conditions to reach are the ones where a line spreads over time or is only partly wrong. Three cases matter:
- a line that pauses halfway and then completes;
- a line with unselected beats of unrelated data mixed in;
- a line that differs only in one ignored high bit, or only in its first beat.

The driver builds each of these on purpose. It splits lines, inserts beats with the select low, and corrupts a chosen beat. For each line it predicts the committed state. The monitor uses the one-cycle drop of `in_ready` to know exactly when to compare.

// File: rtl/ecc_ctl_pkg.sv
package ecc_ctl_pkg;
  localparam int CMD_W = 3;
  localparam int CFG_W = 7;
  localparam logic [CFG_W-1:0] CFG_RESET = 7'h03;

  typedef enum logic [CMD_W-1:0] {
    CMD_FAST   = 3'd0,
    CMD_SLOW   = 3'd1,
    CMD_CFGWR  = 3'd2,
    CMD_NMICLR = 3'd3,
    CMD_RSV4   = 3'd4,
    CMD_CHKON  = 3'd5,
    CMD_CHKOFF = 3'd6,
    CMD_RSV7   = 3'd7
  } cmd_e;

  typedef struct packed {
    logic set_fast;
    logic set_slow;
    logic chk_on;
    logic chk_off;
    logic nmi_clr;
    logic cfg_wr;
  } act_t;
endpackage

// File: rtl/ecc_line_collector.sv
module ecc_line_collector #(
  parameter int DW      = 64,
  parameter int BEATS   = 16,
  parameter int CMD_LSB = 16,
  parameter int CMD_W   = 3,
  parameter int CFG_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sel,
  input  logic [DW-1:0]    in_data,
  output logic             in_ready,
  output logic             done,
  output logic             done_ok,
  output logic [CMD_W-1:0] cmd,
  output logic [CFG_W-1:0] cfg
);
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    first_q;
  logic             bad_q;
  logic             done_q;
  logic             ok_q;
  logic             take;
  logic             beat_bad;

  assign in_ready = !done_q;
  assign take     = in_valid && in_ready && in_sel;
  assign beat_bad = (cnt_q != '0) && (in_data != first_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= '0;
      bad_q   <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        if (cnt_q == '0) begin
          first_q <= in_data;
          bad_q   <= 1'b0;
        end else if (beat_bad) begin
          bad_q <= 1'b1;
        end
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
          ok_q   <= !(bad_q && (cnt_q != '0)) && !beat_bad;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done    = done_q;
  assign done_ok = ok_q;
  assign cmd     = first_q[CMD_LSB +: CMD_W];
  assign cfg     = first_q[CFG_W-1:0];
endmodule

// File: rtl/ecc_cmd_decode.sv
module ecc_cmd_decode
  import ecc_ctl_pkg::*;
(
  input  logic             line_ok,
  input  logic [CMD_W-1:0] cmd,
  output act_t             act
);
  always_comb begin
    act = '0;
    if (line_ok) begin
      unique case (cmd_e'(cmd))
        CMD_FAST:   act.set_fast = 1'b1;
        CMD_SLOW:   act.set_slow = 1'b1;
        CMD_CFGWR:  act.cfg_wr   = 1'b1;
        CMD_NMICLR: act.nmi_clr  = 1'b1;
        CMD_CHKON:  act.chk_on   = 1'b1;
        CMD_CHKOFF: act.chk_off  = 1'b1;
        default:    act          = '0;
      endcase
    end
  end
endmodule

// File: rtl/ecc_mode_regs.sv
module ecc_mode_regs
  import ecc_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  act_t             act,
  input  logic             line_bad,
  input  logic [CFG_W-1:0] cfg_in,
  output logic             fast_mode,
  output logic             chk_en,
  output logic             nmi_clr,
  output logic [CFG_W-1:0] cfg,
  output logic             mismatch
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_mode <= 1'b0;
      chk_en    <= 1'b0;
      nmi_clr   <= 1'b0;
      cfg       <= CFG_RESET;
      mismatch  <= 1'b0;
    end else begin
      nmi_clr <= act.nmi_clr;
      if (act.set_fast) fast_mode <= 1'b1;
      if (act.set_slow) fast_mode <= 1'b0;
      if (act.chk_on)   chk_en    <= 1'b1;
      if (act.chk_off)  chk_en    <= 1'b0;
      if (act.cfg_wr)   cfg       <= cfg_in;
      if (line_bad)     mismatch  <= 1'b1;
    end
  end
endmodule

// File: rtl/ecc_mode_ctl.sv
module ecc_mode_ctl
  import ecc_ctl_pkg::*;
#(
  parameter int DW      = 64,
  parameter int BEATS   = 16,
  parameter int CMD_LSB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sel,
  input  logic [DW-1:0]    in_data,
  output logic             fast_mode,
  output logic             chk_en,
  output logic             nmi_clr,
  output logic [CFG_W-1:0] ecc_cfg,
  output logic             cfg_mismatch,
  output logic [DW-1:0]    rd_data
);
  logic             done;
  logic             done_ok;
  logic [CMD_W-1:0] cmd;
  logic [CFG_W-1:0] cfg_word;
  act_t             act;

  ecc_line_collector #(
    .DW(DW), .BEATS(BEATS), .CMD_LSB(CMD_LSB), .CMD_W(CMD_W), .CFG_W(CFG_W)
  ) u_coll (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
    .in_data(in_data), .in_ready(in_ready), .done(done), .done_ok(done_ok),
    .cmd(cmd), .cfg(cfg_word)
  );

  ecc_cmd_decode u_dec (
    .line_ok(done && done_ok), .cmd(cmd), .act(act)
  );

  ecc_mode_regs u_regs (
    .clk(clk), .rst_n(rst_n), .act(act), .line_bad(done && !done_ok),
    .cfg_in(cfg_word), .fast_mode(fast_mode), .chk_en(chk_en),
    .nmi_clr(nmi_clr), .cfg(ecc_cfg), .mismatch(cfg_mismatch)
  );

  always_comb begin
    rd_data                   = '0;
    rd_data[CFG_W-1:0]        = ecc_cfg;
    rd_data[CMD_LSB]          = fast_mode;
    rd_data[CMD_LSB+1]        = chk_en;
  end
endmodule

// File: rtl/ecc_mode_ctl_chk.sv
module ecc_mode_ctl_chk #(
  parameter int DW      = 64,
  parameter int BEATS   = 16,
  parameter int CMD_LSB = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_sel,
  input logic          fast_mode,
  input logic          chk_en,
  input logic          nmi_clr,
  input logic [6:0]    ecc_cfg,
  input logic          cfg_mismatch,
  input logic [DW-1:0] rd_data
);
  localparam int CW = $clog2(BEATS + 1);
  logic [CW-1:0] seen;
  logic          take;
  assign take = in_valid && in_ready && in_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (take) seen <= (seen == CW'(BEATS - 1)) ? '0 : seen + 1'b1;
  end

  // R7
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> ($stable(fast_mode) && $stable(chk_en) && $stable(ecc_cfg)));
  // R5
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !nmi_clr);
  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_clr |=> !nmi_clr);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mismatch |=> cfg_mismatch);
  // R10
  bubble_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
  // R10
  bubble_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && seen == CW'(BEATS - 1)) |=> !in_ready);
  // R9
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15:7] == '0) && (rd_data[DW-1:CMD_LSB+2] == '0));
endmodule

bind ecc_mode_ctl ecc_mode_ctl_chk #(.DW(DW), .BEATS(BEATS), .CMD_LSB(CMD_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sel(in_sel), .fast_mode(fast_mode), .chk_en(chk_en), .nmi_clr(nmi_clr),
  .ecc_cfg(ecc_cfg), .cfg_mismatch(cfg_mismatch), .rd_data(rd_data)
);

// File: tb/ecc_mode_ctl_tb.sv
module ecc_mode_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_sel = 1'b0;
  logic [63:0] in_data = '0;
  logic in_ready, fast_mode, chk_en, nmi_clr, cfg_mismatch;
  logic [6:0] ecc_cfg;
  logic [63:0] rd_data;

  always #5 clk = ~clk;

  ecc_mode_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sel(in_sel), .in_data(in_data), .fast_mode(fast_mode), .chk_en(chk_en),
    .nmi_clr(nmi_clr), .ecc_cfg(ecc_cfg), .cfg_mismatch(cfg_mismatch),
    .rd_data(rd_data)
  );

  typedef struct packed {
    logic       fast;
    logic       chk;
    logic       mm;
    logic       pulse;
    logic [6:0] cfg;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic m_fast = 0, m_chk = 0, m_mm = 0;
  logic [6:0] m_cfg = 7'h03;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] word(input logic [2:0] c, input logic [15:0] low, input logic [15:0] hi);
    return {hi, 13'h0, c, low};
  endfunction

  // model update for a full line, then queue the expected outcome
  task automatic expect_line(input logic [63:0] w, input bit ok);
    exp_t e;
    logic [2:0] c;
    c = w[18:16];
    e.pulse = 1'b0;
    if (!ok) m_mm = 1'b1;
    else begin
      case (c)
        3'd0: m_fast = 1'b1;
        3'd1: m_fast = 1'b0;
        3'd2: m_cfg  = w[6:0];
        3'd3: e.pulse = 1'b1;
        3'd5: m_chk  = 1'b1;
        3'd6: m_chk  = 1'b0;
        default: ;
      endcase
    end
    e.fast = m_fast; e.chk = m_chk; e.mm = m_mm; e.cfg = m_cfg;
    q.push_back(e);
  endtask

  task automatic beat(input logic [63:0] d, input logic s);
    @(negedge clk);
    in_valid = 1'b1; in_sel = s; in_data = d;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_sel = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic beats(input logic [63:0] w, input int first, input int last,
                       input int bad_at, input int unsel_at);
    for (int i = first; i <= last; i++) begin
      if (i == unsel_at) beat(~w, 1'b0);
      beat((i == bad_at) ? (w ^ 64'h0000_0100_0000_0000) : w, 1'b1);
    end
  endtask

  task automatic line(input logic [63:0] w, input int bad_at, input int unsel_at);
    expect_line(w, bad_at < 0);
    beats(w, 0, 15, bad_at, unsel_at);
    idle(4);
  endtask

  // monitor: the ready bubble marks a commit; outputs settle one edge later
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !in_ready) begin
        exp_t e;
        if (q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R7 actual=commit expected=no commit");
        end else begin
          e = q.pop_front();
          @(negedge clk);
          chk("R2 fast_mode", 64'(fast_mode), 64'(e.fast));
          chk("R3 chk_en", 64'(chk_en), 64'(e.chk));
          chk("R4 ecc_cfg", 64'(ecc_cfg), 64'(e.cfg));
          chk("R8 cfg_mismatch", 64'(cfg_mismatch), 64'(e.mm));
          chk("R5 nmi_clr", 64'(nmi_clr), 64'(e.pulse));
          chk("R10 in_ready", 64'(in_ready), 64'd1);
          chk("R9 rd_data", rd_data, {46'h0, e.chk, e.fast, 9'h0, e.cfg});
          @(negedge clk);
          chk("R5 nmi_clr drop", 64'(nmi_clr), 64'd0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fast_mode", 64'(fast_mode), 64'd0);
    chk("R1 chk_en", 64'(chk_en), 64'd0);
    chk("R1 ecc_cfg", 64'(ecc_cfg), 64'h03);
    chk("R1 cfg_mismatch", 64'(cfg_mismatch), 64'd0);
    chk("R1 nmi_clr", 64'(nmi_clr), 64'd0);
    chk("R10 ready idle", 64'(in_ready), 64'd1);
    chk("R9 rd_data reset", rd_data, 64'h3);

    line(word(3'd0, 16'h0000, 16'h0), -1, -1);   // R2 fast
    line(word(3'd5, 16'h0000, 16'h0), -1, -1);   // R3 on
    line(word(3'd2, 16'hFF5A, 16'hBEEF), -1, -1); // R4 write, 15:7 ignored
    line(word(3'd3, 16'h0011, 16'h0), -1, -1);   // R5 pulse, cfg kept
    line(word(3'd4, 16'h0022, 16'h0), -1, -1);   // R6
    line(word(3'd7, 16'h0033, 16'h0), -1, -1);   // R6
    line(word(3'd1, 16'h0044, 16'h0), -1, -1);   // R2 slow, R4 kept
    line(word(3'd6, 16'h0000, 16'h0), -1, -1);   // R3 off

    // R7 partial line: no change until the last beat
    expect_line(word(3'd0, 16'h0, 16'h0), 1'b1);
    beats(word(3'd0, 16'h0, 16'h0), 0, 4, -1, -1);
    idle(6);
    chk("R7 partial fast_mode", 64'(fast_mode), 64'd0);
    chk("R7 partial ready", 64'(in_ready), 64'd1);
    beats(word(3'd0, 16'h0, 16'h0), 5, 15, -1, -1);
    idle(4);

    line(word(3'd5, 16'h0000, 16'h0), -1, 7);    // R10 unselected beat ignored
    line(word(3'd2, 16'h0009, 16'h0), 9, -1);    // R8 mismatch mid-line
    line(word(3'd2, 16'h000C, 16'h0), 0, -1);    // R8 mismatch first beat
    line(word(3'd2, 16'h0011, 16'h0), -1, -1);   // R8 sticky, R4 write

    idle(4);
    chk("R7 queue drained", 64'(q.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule